// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This controller sits next to a five-stage in-order pipeline made of the stages fetch, decode, execute, memory and writeback. It takes the raw stall requests that the caches, the hazard detector and the multi-cycle ALU raise. It picks one of these requests by a fixed priority and reports it as a single encoded stall cause. It then turns that cause into one hold enable per stage.

It also combines several other conditions into clear enables for the fetch/decode register and the decode/execute register:

- exception reports from decode and execute,
- ordinary flush requests, such as a mispredicted branch,
- a load-use bubble,
- a cache-flush condition, raised by an instruction-stream fence or by a write to the ISA-configuration CSR.

While a cache or ALU stall holds the machine, ordinary flush requests are remembered rather than applied. They take effect in the first cycle after the stall ends. That way no instruction is dropped while a memory access is still in flight.

Every output is registered. An input seen before a rising clock edge shows up at the outputs just after that edge.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: `stall_cause_o` uses this encoding: 0 = none, 1 = instruction miss, 2 = data miss, 3 = load-use, 4 = ALU busy, 5 = fence writeback. No other value ever appears.
- R2: When several stall requests are active, the cause reported is the highest one in this order: fence writeback, then instruction miss, then data miss, then load-use (from fetch or from decode), then ALU busy.
- R3: `hold_o` has bit 0 for fetch, bit 1 for decode, bit 2 for execute, bit 3 for memory and bit 4 for writeback. Causes 2, 4 and 5 set all five bits. Causes 1 and 3 set only bits 0 and 1. Cause 0 sets none.
- R4: A decode or execute flush request is deferred while the cause is 1, 2, 4 or 5, even if the request is a one-cycle pulse. It is applied in the first cycle after such a stall ends, and exactly once.
- R5: An execute exception gives `exc_level_o` = 3 and clears both pipeline registers (`flush_fd_o` and `flush_dx_o`). This holds whether or not decode also reports an exception, and it is never deferred by a stall.
- R6: A decode exception without an execute exception gives `exc_level_o` = 2 and clears only the fetch/decode register. With no exception, `exc_level_o` is 0.
- R7: A fence instruction in the decode/execute register, or a CSR write to address 0x301, raises `cache_flush_o` and `flush_fd_o`. In that case `resume_pc_o` equals that instruction's incremented PC. A CSR write to any other address raises neither output, and `resume_pc_o` then reads 0.
- R8: A load-use stall (cause 3) clears the decode/execute register (one bubble) and holds fetch and decode. It does not clear the fetch/decode register and does not defer flush requests.
- R9: While the synchronous active-high reset is asserted, every output is 0 and any deferred flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fence_wb_req_i | input | 1 | Fence writeback in progress |
| imiss_req_i | input | 1 | Instruction cache miss |
| dmiss_req_i | input | 1 | Data cache miss |
| lduse_fe_req_i | input | 1 | Load-use hazard seen at fetch |
| lduse_de_req_i | input | 1 | Load-use hazard seen at decode |
| alu_busy_req_i | input | 1 | Multi-cycle ALU not done |
| de_flush_req_i | input | 1 | Flush request for the fetch/decode register |
| ex_flush_req_i | input | 1 | Flush request for the decode/execute register |
| de_exc_i | input | 1 | Decode stage holds an exception |
| ex_exc_i | input | 1 | Execute stage holds an exception |
| dx_is_fence_i | input | 1 | Decode/execute register holds an instruction-stream fence |
| dx_csr_wr_i | input | 1 | CSR write in execute |
| dx_csr_addr_i | input | 12 | Address of that CSR write |
| dx_pc_incr_i | input | 32 | Incremented PC of the decode/execute instruction |
| stall_cause_o | output | 3 | Encoded stall cause |
| hold_o | output | 5 | Per-stage hold enables |
| flush_fd_o | output | 1 | Clear fetch/decode register |
| flush_dx_o | output | 1 | Clear decode/execute register |
| exc_level_o | output | 2 | Exception flush level (0, 2 or 3) |
| cache_flush_o | output | 1 | Cache flush raised |
| resume_pc_o | output | 32 | Fetch restart address during a cache flush |

## Verification
The bench goes after these corner cases:

- **Deferral.** It sends a one-cycle flush pulse into a data-miss stall and into a multi-cycle ALU stall. A design that only gates the enable would lose that flush. A design that never clears its pending state would flush twice.
- **Load-use.** It pairs a load-use stall with a flush request. A design that treated load-use as a freezing stall would hold the flush back, and one that got the bubble wrong would leave `flush_dx_o` low.
- **Exception levels.** It drives both exception sources together, to catch a reversed priority between them.
- **CSR address.** It writes a neighbouring CSR address, to catch a cache flush decoded from too few address bits.
- **Reset.** It asserts reset with every request active, to catch outputs that leak through reset.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_IMISS = 3'd1,
    CAUSE_DMISS = 3'd2,
    CAUSE_LDUSE = 3'd3,
    CAUSE_ALU   = 3'd4,
    CAUSE_FENCE = 3'd5
  } cause_e;

  localparam logic [11:0] ISA_CFG_CSR = 12'h301;

  // causes during which ordinary flushes wait
  function automatic logic cause_defers(cause_e c);
    return (c == CAUSE_IMISS) || (c == CAUSE_DMISS) ||
           (c == CAUSE_ALU)   || (c == CAUSE_FENCE);
  endfunction

  // causes that freeze every stage
  function automatic logic cause_freezes_all(cause_e c);
    return (c == CAUSE_DMISS) || (c == CAUSE_ALU) || (c == CAUSE_FENCE);
  endfunction

endpackage

// File: rtl/stall_prio.sv
module stall_prio
  import hzc_pkg::*;
(
  input  logic   fence_req,
  input  logic   imiss_req,
  input  logic   dmiss_req,
  input  logic   lduse_req,
  input  logic   alu_req,
  output cause_e cause
);

  always_comb begin
    cause = CAUSE_NONE;
    if (fence_req)      cause = CAUSE_FENCE;
    else if (imiss_req) cause = CAUSE_IMISS;
    else if (dmiss_req) cause = CAUSE_DMISS;
    else if (lduse_req) cause = CAUSE_LDUSE;
    else if (alu_req)   cause = CAUSE_ALU;
  end

endmodule

// File: rtl/hold_map.sv
module hold_map
  import hzc_pkg::*;
#(
  parameter int NSTAGES = 5,
  parameter int FRONT   = 2
) (
  input  cause_e             cause,
  output logic [NSTAGES-1:0] hold
);

  logic any_stall;
  logic all_stall;

  assign any_stall = (cause != CAUSE_NONE);
  assign all_stall = cause_freezes_all(cause);

  for (genvar s = 0; s < NSTAGES; s++) begin : g_stage
    if (s < FRONT) begin : g_front
      assign hold[s] = any_stall;
    end else begin : g_back
      assign hold[s] = all_stall;
    end
  end

endmodule

// File: rtl/flush_defer.sv
module flush_defer (
  input  logic clk,
  input  logic rst,
  input  logic defer,
  input  logic de_req,
  input  logic ex_req,
  output logic de_en,
  output logic ex_en
);

  logic de_pend_q;
  logic ex_pend_q;

  assign de_en = (de_req || de_pend_q) && !defer;
  assign ex_en = (ex_req || ex_pend_q) && !defer;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_pend_q <= 1'b0;
      ex_pend_q <= 1'b0;
    end else begin
      de_pend_q <= defer && (de_req || de_pend_q);
      ex_pend_q <= defer && (ex_req || ex_pend_q);
    end
  end

  // A pending flush is released by the first cycle without deferral.
  AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (de_pend_q && !defer) |-> de_en);  // R4

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    defer |-> (!de_en && !ex_en));  // R4

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hzc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NSTAGES = 5,
  parameter int FRONT   = 2,
  parameter int CSR_AW  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fence_wb_req_i,
  input  logic               imiss_req_i,
  input  logic               dmiss_req_i,
  input  logic               lduse_fe_req_i,
  input  logic               lduse_de_req_i,
  input  logic               alu_busy_req_i,
  input  logic               de_flush_req_i,
  input  logic               ex_flush_req_i,
  input  logic               de_exc_i,
  input  logic               ex_exc_i,
  input  logic               dx_is_fence_i,
  input  logic               dx_csr_wr_i,
  input  logic [CSR_AW-1:0]  dx_csr_addr_i,
  input  logic [XLEN-1:0]    dx_pc_incr_i,
  output logic [2:0]         stall_cause_o,
  output logic [NSTAGES-1:0] hold_o,
  output logic               flush_fd_o,
  output logic               flush_dx_o,
  output logic [1:0]         exc_level_o,
  output logic               cache_flush_o,
  output logic [XLEN-1:0]    resume_pc_o
);

  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_DE   = 2'd2;
  localparam logic [1:0] LVL_EX   = 2'd3;

  cause_e             cause_d;
  logic [NSTAGES-1:0] hold_d;
  logic               de_en;
  logic               ex_en;
  logic [1:0]         lvl_d;
  logic               cflush_d;

  stall_prio u_prio (
    .fence_req (fence_wb_req_i),
    .imiss_req (imiss_req_i),
    .dmiss_req (dmiss_req_i),
    .lduse_req (lduse_fe_req_i || lduse_de_req_i),
    .alu_req   (alu_busy_req_i),
    .cause     (cause_d)
  );

  hold_map #(.NSTAGES(NSTAGES), .FRONT(FRONT)) u_hold (
    .cause (cause_d),
    .hold  (hold_d)
  );

  flush_defer u_defer (
    .clk    (clk),
    .rst    (rst),
    .defer  (cause_defers(cause_d)),
    .de_req (de_flush_req_i),
    .ex_req (ex_flush_req_i),
    .de_en  (de_en),
    .ex_en  (ex_en)
  );

  assign lvl_d    = ex_exc_i ? LVL_EX : (de_exc_i ? LVL_DE : LVL_NONE);
  assign cflush_d = dx_is_fence_i ||
                    (dx_csr_wr_i && (dx_csr_addr_i == CSR_AW'(ISA_CFG_CSR)));

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_cause_o <= CAUSE_NONE;
      hold_o        <= '0;
      flush_fd_o    <= 1'b0;
      flush_dx_o    <= 1'b0;
      exc_level_o   <= LVL_NONE;
      cache_flush_o <= 1'b0;
      resume_pc_o   <= '0;
    end else begin
      stall_cause_o <= cause_d;
      hold_o        <= hold_d;
      flush_fd_o    <= de_en || (lvl_d != LVL_NONE) || cflush_d;
      flush_dx_o    <= ex_en || (lvl_d == LVL_EX) || (cause_d == CAUSE_LDUSE);
      exc_level_o   <= lvl_d;
      cache_flush_o <= cflush_d;
      resume_pc_o   <= cflush_d ? dx_pc_incr_i : '0;
    end
  end

  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    stall_cause_o <= 3'd5);  // R1

  AST_BACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold_o[NSTAGES-1] |-> (stall_cause_o inside {3'd2, 3'd4, 3'd5}));  // R3

  AST_EXC_CLEARS_BOTH: assert property (@(posedge clk) disable iff (rst)
    (exc_level_o == LVL_EX) |-> (flush_fd_o && flush_dx_o));  // R5

  AST_LVL_VALUES: assert property (@(posedge clk) disable iff (rst)
    exc_level_o != 2'd1);  // R6

  AST_LDUSE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (stall_cause_o == 3'd3) |-> (flush_dx_o && hold_o[0] && !hold_o[FRONT]));  // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (stall_cause_o == 3'd0 && hold_o == '0 && !flush_fd_o &&
             !flush_dx_o && !cache_flush_o));  // R9

endmodule

// File: tb/tb_pipe_hazard_ctrl.sv
module tb_pipe_hazard_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        fence_wb, imiss, dmiss, ldfe, ldde, alu;
  logic        de_req, ex_req, de_exc, ex_exc, dx_fence, csr_wr;
  logic [11:0] csr_addr;
  logic [31:0] pc_incr;
  logic [2:0]  cause;
  logic [4:0]  hold;
  logic        ffd, fdx, cfl;
  logic [1:0]  lvl;
  logic [31:0] rpc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pipe_hazard_ctrl dut (
    .clk(clk), .rst(rst),
    .fence_wb_req_i(fence_wb), .imiss_req_i(imiss), .dmiss_req_i(dmiss),
    .lduse_fe_req_i(ldfe), .lduse_de_req_i(ldde), .alu_busy_req_i(alu),
    .de_flush_req_i(de_req), .ex_flush_req_i(ex_req),
    .de_exc_i(de_exc), .ex_exc_i(ex_exc),
    .dx_is_fence_i(dx_fence), .dx_csr_wr_i(csr_wr),
    .dx_csr_addr_i(csr_addr), .dx_pc_incr_i(pc_incr),
    .stall_cause_o(cause), .hold_o(hold), .flush_fd_o(ffd), .flush_dx_o(fdx),
    .exc_level_o(lvl), .cache_flush_o(cfl), .resume_pc_o(rpc)
  );

  // {fence,imiss,dmiss,ldfe,ldde,alu} , cause , hold
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {6'b000000, 3'd0, 5'b00000},
    {6'b100000, 3'd5, 5'b11111},
    {6'b010000, 3'd1, 5'b00011},
    {6'b001000, 3'd2, 5'b11111},
    {6'b000100, 3'd3, 5'b00011},
    {6'b000010, 3'd3, 5'b00011},
    {6'b000001, 3'd4, 5'b11111},
    {6'b111111, 3'd5, 5'b11111},
    {6'b011111, 3'd1, 5'b00011},
    {6'b001111, 3'd2, 5'b11111},
    {6'b000111, 3'd3, 5'b00011},
    {6'b000011, 3'd3, 5'b00011}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    {fence_wb, imiss, dmiss, ldfe, ldde, alu} = '0;
    {de_req, ex_req, de_exc, ex_exc, dx_fence, csr_wr} = '0;
    csr_addr = '0;
    pc_incr  = '0;
  endtask

  // advance one edge, then sample away from it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_in();
    rst = 1'b1;
    {fence_wb, imiss, dmiss, ldfe, ldde, alu} = '1;
    {de_req, ex_req, ex_exc, dx_fence} = '1;
    pc_incr = 32'h44;
    step();
    step();
    // R9: reset forces everything quiet
    chk("R9 cause", 32'(cause), 0);
    chk("R9 hold", 32'(hold), 0);
    chk("R9 flushes", {29'd0, ffd, fdx, cfl}, 0);
    chk("R9 level", 32'(lvl), 0);
    chk("R9 resume", rpc, 0);
    @(negedge clk);
    clear_in();
    rst = 1'b0;
    step();
    // R9: pending flush from reset time was discarded
    chk("R9 no leftover flush", {30'd0, ffd, fdx}, 0);

    // R1 R2 R3: priority and hold table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      clear_in();
      {fence_wb, imiss, dmiss, ldfe, ldde, alu} = VEC[i][13:8];
      step();
      chk("R1/R2 cause", 32'(cause), 32'(VEC[i][7:5]));
      chk("R3 hold", 32'(hold), 32'(VEC[i][4:0]));
    end

    // R5: both exceptions -> level 3, both registers cleared
    @(negedge clk); clear_in(); de_exc = 1; ex_exc = 1; dmiss = 1;
    step();
    chk("R5 level", 32'(lvl), 3);
    chk("R5 clears", {30'd0, ffd, fdx}, 3);
    // R6: decode only
    @(negedge clk); clear_in(); de_exc = 1;
    step();
    chk("R6 level", 32'(lvl), 2);
    chk("R6 clears", {30'd0, ffd, fdx}, 2);
    @(negedge clk); clear_in();
    step();
    chk("R6 none", 32'(lvl), 0);

    // R7: fence in decode/execute
    @(negedge clk); clear_in(); dx_fence = 1; pc_incr = 32'h0000_1004;
    step();
    chk("R7 fence flush", {30'd0, cfl, ffd}, 3);
    chk("R7 resume", rpc, 32'h0000_1004);
    @(negedge clk); clear_in(); csr_wr = 1; csr_addr = 12'h301; pc_incr = 32'h0000_2002;
    step();
    chk("R7 csr flush", 32'(cfl), 1);
    chk("R7 csr resume", rpc, 32'h0000_2002);
    @(negedge clk); clear_in(); csr_wr = 1; csr_addr = 12'h300; pc_incr = 32'h0000_3000;
    step();
    chk("R7 other csr", {29'd0, cfl, ffd, fdx}, 0);
    chk("R7 other resume", rpc, 0);

    // R4: flush pulse inside a data-miss stall
    @(negedge clk); clear_in(); dmiss = 1; de_req = 1; ex_req = 1;
    step();
    chk("R4 deferred", {30'd0, ffd, fdx}, 0);
    @(negedge clk); clear_in();
    step();
    chk("R4 released", {30'd0, ffd, fdx}, 3);
    step();
    chk("R4 once", {30'd0, ffd, fdx}, 0);

    // R4: pulse held through a three-cycle ALU stall
    @(negedge clk); clear_in(); alu = 1; de_req = 1;
    step();
    chk("R4 alu c1", 32'(ffd), 0);
    @(negedge clk); de_req = 0;
    step();
    chk("R4 alu c2", 32'(ffd), 0);
    step();
    chk("R4 alu c3", 32'(ffd), 0);
    @(negedge clk); clear_in();
    step();
    chk("R4 alu release", {30'd0, ffd, fdx}, 2);

    // R8: load-use does not defer, inserts bubble
    @(negedge clk); clear_in(); ldde = 1; de_req = 1;
    step();
    chk("R8 cause", 32'(cause), 3);
    chk("R8 flush not deferred", {30'd0, ffd, fdx}, 3);
    @(negedge clk); clear_in(); ldfe = 1;
    step();
    chk("R8 bubble only", {30'd0, ffd, fdx}, 1);
    chk("R8 hold front", 32'(hold), 5'b00011);

    @(negedge clk); clear_in();
    step();
    chk("R1 idle", 32'(cause), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule